// File: doc/BRIEF.md
# Phase-Count Tracking Clock Generator

This block sits on the controller side of a ring of daisy-chained power-phase stages. It makes the system clock that all stages share, and it launches the phase token that travels through the ring. After reset it enters a seek mode. In seek mode it runs the system clock at the fastest slot rate and sends one token out of `ph_out`. It then counts whole system-clock slots until the token comes back on `ph_in`. That count becomes the number of active phases N. From then on the system clock runs at N times the switching rate, so the switching period stays fixed at `SW_TICKS` base ticks for every N.

While running, the stages report joins and departures on a three-level shift line. Here that line is modelled as two pulse inputs, `shift_up` and `shift_dn`. A pulse counts only if its width falls inside the valid window. Valid pulses move a pending target count. The live count and the clock divider take the new value only where a switching period ends, so no period is ever cut short. If the token does not return within a bounded number of slots, the block reports a ring fault and goes quiet until reset.

The shift inputs and the outputs are plain control and status pins. No data stream crosses the block edge, so it has no valid/ready handshake and no back-pressure.

Top module: `tc_phase_clkgen`

## Requirements
- R1: After reset the block is in seek mode. `phase_cnt` is 0 and `ring_fault` and `shift_warn` are low. `ph_out` is high for the first seek slot only. In seek mode every slot lasts SW_TICKS/MAX_PH base ticks.
- R2: When `ph_in` is first sampled high in seek mode, the number of seek slots completed since reset becomes N. Run mode starts at the next seek-slot boundary, and `phase_cnt` then shows N.
- R3: A measured count of 0 is clamped to 1. A measured count above MAX_PH is clamped to MAX_PH.
- R4: If `ph_in` has not been seen high when SEEK_LIMIT seek slots have ended, `ring_fault` rises. After that, `ph_out` and `sys_clk` stay low and `phase_cnt` stays 0 until reset.
- R5: In run mode each system-clock slot lasts SW_TICKS/N ticks. `sys_clk` is high for the first floor(slot/2) ticks of each slot. `ph_out` is high during slot 0 of each switching period, so the switching period is SW_TICKS ticks.
- R6: A shift pulse is accepted only if it stays high for SHIFT_MIN to SHIFT_MAX consecutive ticks. It acts on the tick where its low level is first sampled. Shorter or longer pulses have no effect on `phase_cnt`.
- R7: An accepted up pulse raises the target count by one. At MAX_PH the up pulse is ignored. An accepted down pulse lowers the target count by one.
- R8: An accepted down pulse that arrives when the target count is 1 is ignored and sets `shift_warn`. `shift_warn` stays set until reset.
- R9: `phase_cnt` and the slot length change only where a switching period ends. An up pulse and a down pulse accepted on the same tick cancel each other.
- R10: Shift pulses are ignored in seek mode. `ph_in` is ignored in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_in | input | 1 | Token returning from the last stage |
| shift_up | input | 1 | Pulse: a phase joined the ring |
| shift_dn | input | 1 | Pulse: a phase left the ring |
| sys_clk | output | 1 | System clock to all stages |
| ph_out | output | 1 | Phase token to the first stage |
| phase_cnt | output | $clog2(MAX_PH+1) | Active phase count; 0 while seeking or faulted |
| ring_fault | output | 1 | Token did not return in time (sticky) |
| shift_warn | output | 1 | A down shift was refused at count 1 (sticky) |

## Verification
Every output comes straight from state registers. A change of `ph_in`, or of the falling edge of a shift pulse, therefore shows at the outputs one base tick after the edge that samples it. A count change shows at the first period boundary after that. The bench reference model advances on the same rising edge the design uses and compares all five outputs at the following falling edge. Scenario checks wait well past the boundary where a result is due. Where a check must show that something did not change yet, it samples 20 ticks after a pulse that began 10 ticks into a period, which is far from any boundary.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    ST_SEEK  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } tc_state_e;
endpackage

// File: rtl/tc_shift_qual.sv
// Width qualifier for one shift pulse input: accepts on the falling edge
module tc_shift_qual #(
  parameter int MIN_W = 2,
  parameter int MAX_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic accept
);
  localparam int CW = $clog2(MAX_W + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_W + 1);

  logic [CW-1:0] wcnt;
  logic          prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      prev <= 1'b0;
    end else begin
      prev <= pulse_in;
      if (pulse_in) begin
        if (wcnt != SAT) wcnt <= wcnt + 1'b1;
      end else begin
        wcnt <= '0;
      end
    end
  end

  assign accept = prev && !pulse_in &&
                  (wcnt >= CW'(MIN_W)) && (wcnt <= CW'(MAX_W));
endmodule

// File: rtl/tc_slot_timer.sv
// Slot length lookup: index 0 gives the seek rate, index n gives SW_TICKS/n
module tc_slot_timer #(
  parameter int SW_TICKS = 840,
  parameter int MAX_PH   = 8,
  parameter int CNT_W    = 10,
  parameter int PW       = 4
) (
  input  logic [PW-1:0]    rate_sel,
  output logic [CNT_W-1:0] slot_len
);
  logic [CNT_W-1:0] len_tab [0:MAX_PH];

  for (genvar i = 0; i <= MAX_PH; i++) begin : g_len
    if (i == 0) begin : g_seek
      assign len_tab[i] = CNT_W'(SW_TICKS / MAX_PH);
    end else begin : g_run
      assign len_tab[i] = CNT_W'(SW_TICKS / i);
    end
  end

  always_comb begin
    if (int'(rate_sel) <= MAX_PH) slot_len = len_tab[rate_sel];
    else                          slot_len = len_tab[0];
  end
endmodule

// File: rtl/tc_phase_clkgen.sv
module tc_phase_clkgen #(
  parameter int SW_TICKS   = 840,
  parameter int MAX_PH     = 8,
  parameter int SEEK_LIMIT = 16,
  parameter int SHIFT_MIN  = 2,
  parameter int SHIFT_MAX  = 8,
  localparam int PW        = $clog2(MAX_PH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_in,
  input  logic          shift_up,
  input  logic          shift_dn,
  output logic          sys_clk,
  output logic          ph_out,
  output logic [PW-1:0] phase_cnt,
  output logic          ring_fault,
  output logic          shift_warn
);
  import tc_pkg::*;

  localparam int CNT_W = $clog2(SW_TICKS + 1);
  localparam int TW    = $clog2(SEEK_LIMIT + 1);

  function automatic logic [PW-1:0] clip_cnt(input int v);
    if (v < 1)       return PW'(1);
    if (v > MAX_PH)  return PW'(MAX_PH);
    return PW'(v);
  endfunction

  tc_state_e        state;
  logic [CNT_W-1:0] slot_cnt;
  logic [PW-1:0]    slot_idx;
  logic [PW-1:0]    n_cur, n_tgt, n_found, n_tgt_nxt;
  logic [TW-1:0]    seek_cnt;
  logic             found, warn_q, warn_set;
  logic [PW-1:0]    rate_sel;
  logic [CNT_W-1:0] slot_len;
  logic             slot_end, period_end;
  logic             up_ok, dn_ok;

  tc_shift_qual #(.MIN_W(SHIFT_MIN), .MAX_W(SHIFT_MAX)) u_qual_up (
    .clk(clk), .rst_n(rst_n), .pulse_in(shift_up), .accept(up_ok));
  tc_shift_qual #(.MIN_W(SHIFT_MIN), .MAX_W(SHIFT_MAX)) u_qual_dn (
    .clk(clk), .rst_n(rst_n), .pulse_in(shift_dn), .accept(dn_ok));

  assign rate_sel = (state == ST_RUN) ? n_cur : '0;

  tc_slot_timer #(.SW_TICKS(SW_TICKS), .MAX_PH(MAX_PH), .CNT_W(CNT_W), .PW(PW))
    u_slot (.rate_sel(rate_sel), .slot_len(slot_len));

  assign slot_end   = (slot_cnt == slot_len - CNT_W'(1));
  assign period_end = slot_end && (slot_idx == n_cur - PW'(1));

  // Pending target after this tick's qualified shift pulses
  always_comb begin
    n_tgt_nxt = n_tgt;
    warn_set  = 1'b0;
    if (up_ok && !dn_ok) begin
      if (int'(n_tgt) < MAX_PH) n_tgt_nxt = n_tgt + PW'(1);
    end else if (dn_ok && !up_ok) begin
      if (n_tgt > PW'(1)) n_tgt_nxt = n_tgt - PW'(1);
      else                warn_set  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SEEK;
      slot_cnt <= '0;
      slot_idx <= '0;
      n_cur    <= '0;
      n_tgt    <= '0;
      n_found  <= '0;
      seek_cnt <= '0;
      found    <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_SEEK: begin
          slot_cnt <= slot_end ? '0 : slot_cnt + CNT_W'(1);
          if (!found && ph_in) begin
            found   <= 1'b1;
            n_found <= clip_cnt(int'(seek_cnt));
          end
          if (slot_end) begin
            if (found) begin
              state    <= ST_RUN;
              n_cur    <= n_found;
              n_tgt    <= n_found;
              slot_idx <= '0;
            end else if (int'(seek_cnt) == SEEK_LIMIT - 1) begin
              state <= ST_FAULT;
            end else begin
              seek_cnt <= seek_cnt + TW'(1);
            end
          end
        end
        ST_RUN: begin
          n_tgt <= n_tgt_nxt;
          if (warn_set) warn_q <= 1'b1;
          if (slot_end) begin
            slot_cnt <= '0;
            if (period_end) begin
              slot_idx <= '0;
              n_cur    <= n_tgt_nxt;
            end else begin
              slot_idx <= slot_idx + PW'(1);
            end
          end else begin
            slot_cnt <= slot_cnt + CNT_W'(1);
          end
        end
        default: begin
          slot_cnt <= '0;
        end
      endcase
    end
  end

  assign sys_clk    = (state != ST_FAULT) && (slot_cnt < (slot_len >> 1));
  assign ph_out     = ((state == ST_SEEK) && (seek_cnt == '0)) ||
                      ((state == ST_RUN) && (slot_idx == '0));
  assign phase_cnt  = (state == ST_RUN) ? n_cur : '0;
  assign ring_fault = (state == ST_FAULT);
  assign shift_warn = warn_q;
endmodule

// File: rtl/tc_phase_clkgen_chk.sv
module tc_phase_clkgen_chk #(
  parameter int MAX_PH = 8,
  parameter int PW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_clk,
  input logic          ph_out,
  input logic [PW-1:0] phase_cnt,
  input logic          ring_fault,
  input logic          shift_warn
);
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ring_fault |-> (!ph_out && !sys_clk && phase_cnt == '0)); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ring_fault |=> ring_fault); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cnt != '0) |-> (int'(phase_cnt) <= MAX_PH)); // R3
  AST_CNT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(phase_cnt) != '0) && (phase_cnt != $past(phase_cnt))) |-> ph_out); // R9
  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_warn |=> shift_warn); // R8
  AST_WARN_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_warn) |-> (phase_cnt != '0)); // R10
endmodule

bind tc_phase_clkgen tc_phase_clkgen_chk #(.MAX_PH(MAX_PH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_clk(sys_clk), .ph_out(ph_out),
  .phase_cnt(phase_cnt), .ring_fault(ring_fault), .shift_warn(shift_warn));

// File: tb/tc_phase_clkgen_bench.sv
module tc_phase_clkgen_bench;
  localparam int SW = 840, MAXP = 8, LIM = 16, MINW = 2, MAXW = 8;
  localparam int SEEK_SLOT = SW / MAXP;

  logic clk = 1'b0, rst_n = 1'b0, ph_in = 1'b0, shift_up = 1'b0, shift_dn = 1'b0;
  logic sys_clk, ph_out, ring_fault, shift_warn;
  logic [3:0] phase_cnt;

  tc_phase_clkgen u_tc_phase_clkgen (
    .clk(clk), .rst_n(rst_n), .ph_in(ph_in), .shift_up(shift_up), .shift_dn(shift_dn),
    .sys_clk(sys_clk), .ph_out(ph_out), .phase_cnt(phase_cnt),
    .ring_fault(ring_fault), .shift_warn(shift_warn));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Ring of stages: pure tick delay of ph_out; 0 means open ring
  int ring_len = 0;
  bit dline[$];
  always @(posedge clk) begin
    if (!rst_n) dline.delete();
    else begin
      dline.push_back(ph_out);
      if (dline.size() > ring_len) void'(dline.pop_front());
    end
  end
  always @(negedge clk)
    ph_in <= (ring_len > 0 && dline.size() == ring_len) ? dline[0] : 1'b0;

  // Behavioural reference model
  int m_st, m_sc, m_si, m_n, m_tgt, m_nf, m_tok, m_upw, m_dnw;
  bit m_found, m_warn, m_upp, m_dnp, m_live;

  function automatic int slot_of(int st, int n);
    return (st == 1) ? SW / n : SW / MAXP;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sc = 0; m_si = 0; m_n = 0; m_tgt = 0; m_nf = 0; m_tok = 0;
      m_upw = 0; m_dnw = 0; m_found = 0; m_warn = 0; m_upp = 0; m_dnp = 0; m_live = 0;
    end else begin
      int sl;
      bit send, upk, dnk, oldf;
      sl   = slot_of(m_st, m_n);
      send = (m_sc == sl - 1);
      upk  = m_upp && !shift_up && m_upw >= MINW && m_upw <= MAXW;
      dnk  = m_dnp && !shift_dn && m_dnw >= MINW && m_dnw <= MAXW;
      m_upp = shift_up; m_dnp = shift_dn;
      m_upw = shift_up ? ((m_upw < MAXW + 1) ? m_upw + 1 : m_upw) : 0;
      m_dnw = shift_dn ? ((m_dnw < MAXW + 1) ? m_dnw + 1 : m_dnw) : 0;
      if (m_st == 0) begin
        oldf = m_found;
        m_sc = send ? 0 : m_sc + 1;
        if (!oldf && ph_in) begin
          m_found = 1;
          m_nf = (m_tok < 1) ? 1 : ((m_tok > MAXP) ? MAXP : m_tok);
        end
        if (send) begin
          if (oldf) begin m_st = 1; m_n = m_nf; m_tgt = m_nf; m_si = 0; end
          else if (m_tok == LIM - 1) m_st = 2;
          else m_tok++;
        end
      end else if (m_st == 1) begin
        if (upk && !dnk) begin if (m_tgt < MAXP) m_tgt++; end
        else if (dnk && !upk) begin if (m_tgt > 1) m_tgt--; else m_warn = 1; end
        if (send) begin
          m_sc = 0;
          if (m_si == m_n - 1) begin m_si = 0; m_n = m_tgt; end
          else m_si++;
        end else m_sc++;
      end else m_sc = 0;
      m_live = 1;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_live && !done) begin
      int e_sys, e_ph, e_cnt;
      e_sys = (m_st != 2) && (m_sc < slot_of(m_st, m_n) / 2);
      e_ph  = (m_st == 0 && m_tok == 0) || (m_st == 1 && m_si == 0);
      e_cnt = (m_st == 1) ? m_n : 0;
      chk(sys_clk == e_sys, "R5 sys_clk model", sys_clk, e_sys);
      chk(ph_out == e_ph, "R5 ph_out model", ph_out, e_ph);
      chk(int'(phase_cnt) == e_cnt, "R2 phase_cnt model", phase_cnt, e_cnt);
      chk(ring_fault == (m_st == 2), "R4 ring_fault model", ring_fault, m_st == 2);
      chk(shift_warn == m_warn, "R8 shift_warn model", shift_warn, m_warn);
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input int len);
    @(negedge clk);
    rst_n = 1'b0; ring_len = len; shift_up = 0; shift_dn = 0;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
  endtask

  task automatic pulse(input bit up, input bit dn, input int w);
    shift_up = up; shift_dn = dn;
    ticks(w);
    shift_up = 0; shift_dn = 0;
    ticks(2);
  endtask

  task automatic wait_rise(ref logic s);
    while (s) @(negedge clk);
    while (!s) @(negedge clk);
  endtask

  task automatic period_of(ref logic s, output int p);
    wait_rise(s);
    p = 0;
    while (s) begin @(negedge clk); p++; end
    while (!s) begin @(negedge clk); p++; end
  endtask

  int p;

  initial begin
    // Three-stage ring, token back mid-slot 3
    restart(3 * SEEK_SLOT + 50);
    chk(phase_cnt == 0 && !ring_fault && !shift_warn && ph_out, "R1 reset state", phase_cnt, 0);
    period_of(sys_clk, p);
    chk(p == SEEK_SLOT, "R1 seek slot length", p, SEEK_SLOT);
    ticks(900);
    chk(phase_cnt == 3, "R2 measured count", phase_cnt, 3);
    period_of(sys_clk, p);
    chk(p == SW / 3, "R5 clock period N=3", p, SW / 3);
    period_of(ph_out, p);
    chk(p == SW, "R5 switching period", p, SW);
    ticks(10);
    pulse(1, 0, 4);
    ticks(14);
    chk(phase_cnt == 3, "R9 no change mid-period", phase_cnt, 3);
    ticks(1700);
    chk(phase_cnt == 4, "R7 up shift", phase_cnt, 4);
    chk(phase_cnt == 4, "R10 ph_in ignored in run", phase_cnt, 4);
    period_of(sys_clk, p);
    chk(p == SW / 4, "R5 clock period N=4", p, SW / 4);
    pulse(0, 1, 1);
    pulse(0, 1, 12);
    ticks(1700);
    chk(phase_cnt == 4, "R6 out-of-window pulses ignored", phase_cnt, 4);
    pulse(1, 1, 4);
    ticks(1700);
    chk(phase_cnt == 4, "R9 simultaneous up/down cancel", phase_cnt, 4);
    pulse(0, 1, 3);
    pulse(0, 1, 8);
    ticks(1700);
    chk(phase_cnt == 2, "R7 two down shifts", phase_cnt, 2);

    // Single-stage ring, refused down shift
    restart(SEEK_SLOT + 50);
    ticks(600);
    chk(phase_cnt == 1, "R2 single stage", phase_cnt, 1);
    pulse(0, 1, 5);
    ticks(1700);
    chk(shift_warn && phase_cnt == 1, "R8 refused down shift", phase_cnt, 1);
    pulse(1, 0, 5);
    ticks(1700);
    chk(shift_warn && phase_cnt == 2, "R8 warn sticky after up", shift_warn, 1);

    // Long ring clamps to MAX_PH
    restart(12 * SEEK_SLOT + 50);
    ticks(1500);
    chk(phase_cnt == MAXP, "R3 clamp high", phase_cnt, MAXP);
    pulse(1, 0, 5);
    ticks(1700);
    chk(phase_cnt == MAXP, "R7 up at max ignored", phase_cnt, MAXP);

    // Token back inside slot 0 clamps to 1
    restart(50);
    ticks(400);
    chk(phase_cnt == 1, "R3 clamp low", phase_cnt, 1);

    // Open ring: fault; shifts during seek ignored
    restart(0);
    ticks(20);
    pulse(0, 1, 5);
    pulse(1, 0, 5);
    ticks(LIM * SEEK_SLOT + 100);
    chk(ring_fault && !ph_out && !sys_clk && phase_cnt == 0, "R4 fault quiet", ring_fault, 1);
    chk(!shift_warn, "R10 shifts ignored in seek", shift_warn, 0);
    ticks(500);
    chk(ring_fault, "R4 fault sticky", ring_fault, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule